// File: doc/BRIEF.md
# Parallel Host-Bus Slave Port

This block lets an external host controller exchange bytes with an on-chip controller over an asynchronous parallel bus. The host drives four control lines: a command/data select, an active-low chip select, an active-low write strobe and an active-low read strobe. Together they pick one of four access types. Host writes fill a command register or a data FIFO. Host reads return either a status byte or a byte that the internal side has handed over for reading. All host inputs are resynchronised to the system clock before use. Nothing in the block is clocked by the host strobes.

The data bus carries full bytes in byte mode. When `nib_mode` is high it uses four lines only, and every byte crosses as two transfers, the low nibble first. The bidirectional bus is split into an input, an output and an output enable, so a pad ring can join them. The block drives the bus from the falling edge of a read strobe until chip select is released.

The internal side reads commands and FIFO bytes through valid/ready outputs, and supplies read bytes through a valid/ready input. It writes a field of request bits in the status register. While any request bit is set, the host interrupt line is asserted, which tells the host to poll status.

Top module: `hbus_slave`

## Requirements
- R1: The access type is decoded from the select and the strobe. Select high with a write stores the command register. Select high with a read returns the status byte. Select low with a write pushes the data FIFO. Select low with a read returns the read-data byte.
- R2: A host command write loads `cmd_byte` and raises `cmd_valid`, which stays high until a cycle with `cmd_ready` high. A later command write overwrites the byte.
- R3: The status byte holds the sticky overflow flag in bit 7, read-data-waiting in bit 6 and command-pending in bit 5. Bits 4..0 hold the request field, which the internal side loads through `stat_we`/`stat_req`.
- R4: `hb_irq` is high exactly while the request field is nonzero, from the cycle after the `stat_we` that set it.
- R5: Host data writes leave on `wdat_byte`/`wdat_valid` in arrival order, one per `wdat_ready` handshake, and FIFO_DEPTH bytes can be held.
- R6: A data write into a full FIFO is discarded and sets the overflow flag. The flag stays set until a complete status read, and is clear afterwards.
- R7: One read-data byte is held. `rdat_ready` is high while the holder is empty. A complete data read empties it. A data read with the holder empty returns 0x00 and removes nothing.
- R8: `hb_doe` rises after a read-strobe falling edge with chip select low. It stays high until chip select rises, and is low at all other times, including during writes.
- R9: In nibble mode, each byte of every access type moves as two strobes on data lines 3..0, the low nibble first. Output lines 7..4 are zero. A byte takes effect on the second strobe.
- R10: Releasing chip select in nibble mode returns the nibble phase to the low nibble. A lone nibble therefore does not shift later bytes.
- R11: Any number of bytes may follow one another within a single chip-select assertion, with one strobe per byte (one per nibble in nibble mode).
- R12: A write takes effect on the third clock edge after the rising edge of the write strobe, and not before it (two synchroniser stages and one edge detect).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nib_mode | input | 1 | 1 selects the 4-bit nibble bus; change only while chip select is high |
| hb_sel | input | 1 | Host select: 1 command/status, 0 data |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_wr_n | input | 1 | Host write strobe, active low |
| hb_rd_n | input | 1 | Host read strobe, active low |
| hb_din | input | 8 | Host data bus input |
| hb_dout | output | 8 | Host data bus output value |
| hb_doe | output | 1 | Host data bus output enable |
| hb_irq | output | 1 | Interrupt to host, high while a request is pending |
| cmd_byte | output | 8 | Command register contents |
| cmd_valid | output | 1 | Unconsumed command present |
| cmd_ready | input | 1 | Internal side accepts the command |
| wdat_byte | output | 8 | Head of the data FIFO |
| wdat_valid | output | 1 | FIFO not empty |
| wdat_ready | input | 1 | Internal side pops the FIFO head |
| rdat_byte | input | 8 | Byte offered for host reads |
| rdat_valid | input | 1 | Offered byte valid |
| rdat_ready | output | 1 | Read-data holder empty |
| stat_we | input | 1 | Load the request field |
| stat_req | input | 5 | Request field value |

## Verification
Each host edge passes through two synchroniser flops and an edge-detect register, so every host-side effect is due on the third rising clock edge after the input changes. The bench changes inputs only on falling edges and holds every bus phase for ten cycles, which equals the 100 ns minimum. A directed check samples the command register after two edges, where it must still hold its old value, and again after the third edge, where it must show the new one. Internal-side effects appear one edge after the handshake cycle. Those checks are made at the next falling edge.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   localparam int BYTE_W  = 8;
   localparam int NIB_W   = BYTE_W / 2;
   localparam int REQ_W   = 5;

   localparam int ST_OVF  = 7;
   localparam int ST_RDAV = 6;
   localparam int ST_CMDP = 5;

   typedef enum logic [1:0] {
      ACC_CMD_WR  = 2'b10,
      ACC_STAT_RD = 2'b11,
      ACC_DATA_WR = 2'b00,
      ACC_DATA_RD = 2'b01
   } acc_e;

   function automatic acc_e acc_decode(input logic sel, input logic is_read);
      return acc_e'({sel, is_read});
   endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_st
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[0] <= RST_VAL;
               else        stage[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[i] <= RST_VAL;
               else        stage[i] <= stage[i-1];
            end
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/hbus_fifo.sv
module hbus_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   output logic          full,
   output logic [DW-1:0] head,
   output logic          head_valid,
   input  logic          pop
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("hbus_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          do_pop;

   assign full       = (count == CW'(DEPTH));
   assign head_valid = (count != '0);
   assign head       = mem[rptr];
   assign do_pop     = pop && head_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push && !full) wptr <= wptr + 1'b1;
         if (do_pop)        rptr <= rptr + 1'b1;
         count <= count + CW'(push && !full) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wptr] <= push_data;
   end

   // R6: the port logic must drop writes itself when the FIFO is full
   assert_push_not_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R5: a pop with data present frees a slot by the next cycle
   assert_pop_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && !push) |=> !full);
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
   import hbus_pkg::*;
#(
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int NIBBLE_EN   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nib_mode,
   input  logic              hb_sel,
   input  logic              hb_cs_n,
   input  logic              hb_wr_n,
   input  logic              hb_rd_n,
   input  logic [BYTE_W-1:0] hb_din,
   output logic [BYTE_W-1:0] hb_dout,
   output logic              hb_doe,
   output logic              hb_irq,
   output logic [BYTE_W-1:0] cmd_byte,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [BYTE_W-1:0] wdat_byte,
   output logic              wdat_valid,
   input  logic              wdat_ready,
   input  logic [BYTE_W-1:0] rdat_byte,
   input  logic              rdat_valid,
   output logic              rdat_ready,
   input  logic              stat_we,
   input  logic [REQ_W-1:0]  stat_req
);
   localparam int SW = BYTE_W + 4;
   localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {BYTE_W{1'b0}}};

   // ---------------- synchronised host inputs ----------------
   logic [SW-1:0]     s_bus;
   logic              s_sel, s_cs, s_wr, s_rd;
   logic [BYTE_W-1:0] s_din;
   logic              p_wr, p_rd;

   hbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hb_sel, hb_cs_n, hb_wr_n, hb_rd_n, hb_din}),
      .q     (s_bus)
   );
   assign {s_sel, s_cs, s_wr, s_rd, s_din} = s_bus;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_wr <= 1'b1;
         p_rd <= 1'b1;
      end else begin
         p_wr <= s_wr;
         p_rd <= s_rd;
      end
   end

   logic wr_rise, rd_rise, rd_fall;
   assign wr_rise = s_wr && !p_wr && !s_cs;
   assign rd_rise = s_rd && !p_rd && !s_cs;
   assign rd_fall = !s_rd && p_rd && !s_cs;

   // ---------------- bus width variant ----------------
   logic nib_on;
   generate
      if (NIBBLE_EN != 0) begin : g_nib
         assign nib_on = nib_mode;
      end else begin : g_byte_only
         assign nib_on = 1'b0;
      end
   endgenerate

   logic             phase;
   logic [NIB_W-1:0] lo_nib;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= 1'b0;
         lo_nib <= '0;
      end else begin
         if (s_cs || !nib_on)         phase <= 1'b0;
         else if (wr_rise || rd_rise) phase <= !phase;
         if (nib_on && wr_rise && !phase) lo_nib <= s_din[NIB_W-1:0];
      end
   end

   logic              last_xfer;
   logic [BYTE_W-1:0] wbyte;
   assign last_xfer = !nib_on || phase;
   assign wbyte     = nib_on ? {s_din[NIB_W-1:0], lo_nib} : s_din;

   acc_e acc;
   assign acc = acc_decode(s_sel, rd_rise || rd_fall);

   logic cmd_commit, data_commit, stat_done, data_rd_done, rd_first;
   assign cmd_commit   = wr_rise && last_xfer && (acc == ACC_CMD_WR);
   assign data_commit  = wr_rise && last_xfer && (acc == ACC_DATA_WR);
   assign stat_done    = rd_rise && last_xfer && (acc == ACC_STAT_RD);
   assign data_rd_done = rd_rise && last_xfer && (acc == ACC_DATA_RD);
   assign rd_first     = rd_fall && !(nib_on && phase);

   // ---------------- command register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_byte  <= '0;
         cmd_valid <= 1'b0;
      end else if (cmd_commit) begin
         cmd_byte  <= wbyte;
         cmd_valid <= 1'b1;
      end else if (cmd_ready) begin
         cmd_valid <= 1'b0;
      end
   end

   // ---------------- write FIFO ----------------
   logic fifo_full, ovf;

   hbus_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) i_wfifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (data_commit && !fifo_full),
      .push_data  (wbyte),
      .full       (fifo_full),
      .head       (wdat_byte),
      .head_valid (wdat_valid),
      .pop        (wdat_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ovf <= 1'b0;
      else if (data_commit && fifo_full) ovf <= 1'b1;
      else if (stat_done)                ovf <= 1'b0;
   end

   // ---------------- status and interrupt ----------------
   logic [REQ_W-1:0]  req_q;
   logic [BYTE_W-1:0] status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       req_q <= '0;
      else if (stat_we) req_q <= stat_req;
   end
   assign hb_irq = |req_q;

   // ---------------- read-data holder ----------------
   logic              hold_full;
   logic [BYTE_W-1:0] hold_byte;

   assign rdat_ready = !hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_byte <= '0;
      end else if (rdat_valid && !hold_full) begin
         hold_full <= 1'b1;
         hold_byte <= rdat_byte;
      end else if (data_rd_done) begin
         hold_full <= 1'b0;
      end
   end

   always_comb begin
      status          = '0;
      status[ST_OVF]  = ovf;
      status[ST_RDAV] = hold_full;
      status[ST_CMDP] = cmd_valid;
      status[REQ_W-1:0] = req_q;
   end

   // ---------------- host read path ----------------
   logic [BYTE_W-1:0] out_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_byte <= '0;
         hb_doe   <= 1'b0;
      end else begin
         if (rd_first)
            out_byte <= s_sel ? status : (hold_full ? hold_byte : '0);
         if (s_cs)         hb_doe <= 1'b0;
         else if (rd_fall) hb_doe <= 1'b1;
      end
   end

   always_comb begin
      if (!hb_doe)     hb_dout = '0;
      else if (nib_on) hb_dout = {{NIB_W{1'b0}}, phase ? out_byte[BYTE_W-1:NIB_W] : out_byte[NIB_W-1:0]};
      else             hb_dout = out_byte;
   end

   // ---------------- assertions ----------------
   assert_cmd_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_commit |=> (cmd_valid && cmd_byte == $past(wbyte)));
   assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_commit && fifo_full) |=> ovf);
   assert_irq_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && stat_req != '0) |=> hb_irq);
   assert_irq_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && stat_req == '0) |=> !hb_irq);
   assert_release_on_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      s_cs |=> !hb_doe);
   assert_drive_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_doe && !$past(hb_doe)) |-> $past(rd_fall));
   assert_phase_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      s_cs |=> !phase);
   assert_upper_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      nib_on |-> (hb_dout[BYTE_W-1:NIB_W] == '0));
endmodule

// File: tb/test_hbus_slave.sv
module test_hbus_slave;
   localparam int DEPTH = 4;
   localparam int PH    = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nib_mode = 1'b0;
   logic       hb_sel = 1'b0, hb_cs_n = 1'b1, hb_wr_n = 1'b1, hb_rd_n = 1'b1;
   logic [7:0] hb_din = 8'h00;
   logic [7:0] hb_dout;
   logic       hb_doe, hb_irq;
   logic [7:0] cmd_byte;
   logic       cmd_valid;
   logic       cmd_ready = 1'b0;
   logic [7:0] wdat_byte;
   logic       wdat_valid;
   logic       wdat_ready = 1'b0;
   logic [7:0] rdat_byte = 8'h00;
   logic       rdat_valid = 1'b0;
   logic       rdat_ready;
   logic       stat_we = 1'b0;
   logic [4:0] stat_req = 5'h00;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done = 0;

   always #5 clk = ~clk;

   hbus_slave #(.FIFO_DEPTH(DEPTH)) i_hbus_slave (
      .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode),
      .hb_sel(hb_sel), .hb_cs_n(hb_cs_n), .hb_wr_n(hb_wr_n), .hb_rd_n(hb_rd_n),
      .hb_din(hb_din), .hb_dout(hb_dout), .hb_doe(hb_doe), .hb_irq(hb_irq),
      .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .wdat_byte(wdat_byte), .wdat_valid(wdat_valid), .wdat_ready(wdat_ready),
      .rdat_byte(rdat_byte), .rdat_valid(rdat_valid), .rdat_ready(rdat_ready),
      .stat_we(stat_we), .stat_req(stat_req)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status(input bit ovf, input bit rdav,
                                             input bit cmdp, input logic [4:0] req);
      return {ovf, rdav, cmdp, req};
   endfunction

   task automatic hb_open(input logic sel);
      hb_sel = sel;
      wait_cyc(PH);
      hb_cs_n = 1'b0;
      wait_cyc(PH);
   endtask

   task automatic hb_close();
      wait_cyc(PH);
      hb_cs_n = 1'b1;
      wait_cyc(PH);
   endtask

   task automatic wstrobe(input logic [7:0] v);
      hb_din = v;
      wait_cyc(PH);
      hb_wr_n = 1'b0;
      wait_cyc(PH);
      chk("R8 no drive on write", hb_doe, 1'b0);
      hb_wr_n = 1'b1;
      wait_cyc(2 * PH);
   endtask

   task automatic rstrobe(output logic [7:0] v);
      hb_rd_n = 1'b0;
      wait_cyc(PH);
      chk("R8 drive during read", hb_doe, 1'b1);
      if (nib_mode) chk("R9 upper lines zero", hb_dout[7:4], 4'h0);
      v = hb_dout;
      hb_rd_n = 1'b1;
      wait_cyc(PH);
   endtask

   task automatic put_byte(input logic [7:0] b);
      if (nib_mode) begin
         wstrobe({4'h0, b[3:0]});
         wstrobe({4'h0, b[7:4]});
      end else begin
         wstrobe(b);
      end
   endtask

   task automatic get_byte(output logic [7:0] b);
      logic [7:0] lo, hi;
      if (nib_mode) begin
         rstrobe(lo);
         rstrobe(hi);
         b = {hi[3:0], lo[3:0]};
      end else begin
         rstrobe(b);
      end
   endtask

   task automatic read_status(output logic [7:0] s);
      hb_open(1'b1);
      get_byte(s);
      hb_close();
   endtask

   task automatic load_hold(input logic [7:0] v);
      rdat_byte  = v;
      rdat_valid = 1'b1;
      wait_cyc(1);
      rdat_valid = 1'b0;
      wait_cyc(1);
   endtask

   task automatic pop_fifo();
      wdat_ready = 1'b1;
      wait_cyc(1);
      wdat_ready = 1'b0;
      wait_cyc(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R12 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, st, b, r;
      logic [7:0] vals [DEPTH + 2];
      void'($urandom(32'h5eed_0042));
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(2);

      // reset state
      chk("R4 irq at reset", hb_irq, 1'b0);
      chk("R8 bus released at reset", hb_doe, 1'b0);
      chk("R2 no command at reset", cmd_valid, 1'b0);
      chk("R5 fifo empty at reset", wdat_valid, 1'b0);
      chk("R7 holder empty at reset", rdat_ready, 1'b1);

      // R1 R2: command writes, overwrite, accept
      hb_open(1'b1); put_byte(8'hA5); hb_close();
      chk("R1 command write byte", cmd_byte, 8'hA5);
      chk("R2 command valid", cmd_valid, 1'b1);
      hb_open(1'b1); put_byte(8'h3C); hb_close();
      chk("R2 command overwrite", cmd_byte, 8'h3C);
      cmd_ready = 1'b1; wait_cyc(1); cmd_ready = 1'b0; wait_cyc(1);
      chk("R2 command accepted", cmd_valid, 1'b0);

      // R12: effect due on the third edge after the write strobe rises
      hb_open(1'b1);
      hb_din = 8'h6B; wait_cyc(PH);
      hb_wr_n = 1'b0; wait_cyc(PH);
      hb_wr_n = 1'b1;
      wait_cyc(2);
      chk("R12 not before third edge", cmd_byte, 8'h3C);
      wait_cyc(1);
      chk("R12 at third edge", cmd_byte, 8'h6B);
      hb_close();
      cmd_ready = 1'b1; wait_cyc(1); cmd_ready = 1'b0; wait_cyc(1);

      // R3 R4: request field, interrupt, status read
      stat_req = 5'h12; stat_we = 1'b1; wait_cyc(1); stat_we = 1'b0; wait_cyc(1);
      chk("R4 irq raised", hb_irq, 1'b1);
      read_status(st);
      chk("R3 status layout", st, exp_status(0, 0, 0, 5'h12));
      stat_req = 5'h00; stat_we = 1'b1; wait_cyc(1); stat_we = 1'b0; wait_cyc(1);
      chk("R4 irq cleared", hb_irq, 1'b0);

      // R5 R6 R11: burst into FIFO past its depth in one chip select
      for (int k = 0; k < DEPTH + 2; k++) vals[k] = 8'($urandom);
      hb_open(1'b0);
      for (int k = 0; k < DEPTH + 2; k++) put_byte(vals[k]);
      chk("R8 still driving none after writes", hb_doe, 1'b0);
      hb_close();
      read_status(st);
      chk("R6 overflow flagged", st, exp_status(1, 0, 0, 5'h00));
      for (int k = 0; k < DEPTH; k++) begin
         chk("R5 fifo valid", wdat_valid, 1'b1);
         chk("R11 fifo order", wdat_byte, vals[k]);
         pop_fifo();
      end
      chk("R6 dropped bytes absent", wdat_valid, 1'b0);
      read_status(st);
      chk("R6 overflow cleared by status read", st, exp_status(0, 0, 0, 5'h00));

      // R7 R8: read-data holder
      hb_open(1'b0); get_byte(v);
      chk("R7 empty holder reads zero", v, 8'h00);
      hb_close();
      load_hold(8'h5A);
      chk("R7 holder full", rdat_ready, 1'b0);
      read_status(st);
      chk("R3 read data waiting bit", st, exp_status(0, 1, 0, 5'h00));
      hb_open(1'b0); get_byte(v);
      chk("R1 data read", v, 8'h5A);
      wait_cyc(PH);
      chk("R8 drive held until chip select rises", hb_doe, 1'b1);
      hb_close();
      chk("R8 released after chip select", hb_doe, 1'b0);
      chk("R7 holder emptied", rdat_ready, 1'b1);

      // R9: nibble mode for each access type
      nib_mode = 1'b1; wait_cyc(2);
      hb_open(1'b1); put_byte(8'hC7); hb_close();
      chk("R9 nibble command", cmd_byte, 8'hC7);
      cmd_ready = 1'b1; wait_cyc(1); cmd_ready = 1'b0; wait_cyc(1);
      load_hold(8'h3E);
      hb_open(1'b0); get_byte(v); hb_close();
      chk("R9 nibble data read", v, 8'h3E);
      stat_req = 5'h09; stat_we = 1'b1; wait_cyc(1); stat_we = 1'b0; wait_cyc(1);
      read_status(st);
      chk("R9 nibble status read", st, exp_status(0, 0, 0, 5'h09));
      stat_req = 5'h00; stat_we = 1'b1; wait_cyc(1); stat_we = 1'b0; wait_cyc(1);
      hb_open(1'b0); put_byte(8'hD2); put_byte(8'h81); hb_close();
      chk("R11 nibble burst first", wdat_byte, 8'hD2); pop_fifo();
      chk("R11 nibble burst second", wdat_byte, 8'h81); pop_fifo();

      // R10: lone nibble then full byte
      hb_open(1'b1); wstrobe(8'h09); hb_close();
      hb_open(1'b1); put_byte(8'h42); hb_close();
      chk("R10 phase realigned", cmd_byte, 8'h42);
      cmd_ready = 1'b1; wait_cyc(1); cmd_ready = 1'b0; wait_cyc(1);

      // random mix of modes and values
      for (int it = 0; it < 12; it++) begin
         nib_mode = 1'($urandom);
         wait_cyc(2);
         b = 8'($urandom);
         r = 8'($urandom);
         hb_open(1'b0); put_byte(b); hb_close();
         chk("R5 random data write", wdat_byte, b);
         pop_fifo();
         load_hold(r);
         hb_open(1'b0); get_byte(v); hb_close();
         chk("R7 random data read", v, r);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule